// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from up to eleven peripheral sources into a latched status word. It drives a single interrupt line toward the processor whenever a latched bit is also enabled in a mask word. Software reaches both words through a small register bus that has an address, a write strobe, a 32-bit write data bus and a combinational read data bus. A 16-bit access uses the low half of the data bus.

Acknowledging a request is done by writing the status word. Each zero in the written value clears the matching status bit, and each one leaves that bit as it was. So software writes the complement of the bits it has serviced. The mask word is a plain stored value. The combined completion interrupt of the DMA engine is wired to source bit 3.

Address decode looks at bits 28 down to 2 only. The three top bits select mirrored segments, and all of them reach the same two words.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: While reset is asserted at a clock edge, status, mask and the `irq` output are all cleared to zero after that edge.
- R2: A source request bit that is high at a clock edge sets the matching status bit after that edge. The bit then stays set until it is acknowledged. Source bit 3 carries the DMA engine's combined interrupt.
- R3: A write to the status word (page base 0x1F80_1000 plus 0x070) replaces status with status AND the low `NSRC` bits of the write data. Zero bits clear and one bits preserve.
- R4: When a source request and an acknowledge hit the same status bit at the same edge, the bit is set after that edge.
- R5: A write to the mask word (page base plus 0x074) stores the low `NSRC` bits of the write data unchanged.
- R6: `irq` is a register. After each edge it equals the OR over all bits of (status AND mask) as updated at that same edge. This includes a mask write that exposes a bit that is already pending.
- R7: Address bits 31 to 29 and 1 to 0 are ignored by decode. For example, 0x9F80_1070 reaches the status word and 0xBF80_1074 reaches the mask word.
- R8: A write to any other address changes neither word. A read of any other address returns zero.
- R9: Reads of the status or mask word return the value zero-extended to 32 bits, so bits `NSRC` and above read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Register bus address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data; a 16-bit access uses bits 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_req | input | NSRC | Peripheral request inputs, bit 3 from the DMA engine |
| irq | output | 1 | Interrupt line to the processor |

## Verification
Every register update falls on the edge that samples the stimulus, so status, mask and `irq` are due one edge after it. Read data follows the address combinationally, with no added latency. The bench drives a write or request on a falling edge and lets one rising edge pass. On the next falling edge it points the address at the word under test, withdraws the strobe, and compares `bus_rdata` and `irq` a moment later. Each check therefore sees exactly one edge of effect, and the strobe is already low before any further edge can act.

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl #(
  parameter int          NSRC      = 11,
  parameter logic [31:0] PAGE_BASE = 32'h1F80_1000,
  parameter logic [11:0] STAT_OFS  = 12'h070,
  parameter logic [11:0] MASK_OFS  = 12'h074
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_req,
  output logic            irq
);
  localparam logic [31:0] STAT_ADDR = PAGE_BASE + {20'd0, STAT_OFS};
  localparam logic [31:0] MASK_ADDR = PAGE_BASE + {20'd0, MASK_OFS};

  logic [NSRC-1:0] stat, mask, stat_d, mask_d;

  wire hit_stat = bus_addr[28:2] == STAT_ADDR[28:2];
  wire hit_mask = bus_addr[28:2] == MASK_ADDR[28:2];
  wire [NSRC-1:0] wval = bus_wdata[NSRC-1:0];

  wire unused_bits = ^{bus_addr[31:29], bus_addr[1:0], bus_wdata[31:NSRC]};

  assign stat_d = (stat & ((bus_wr && hit_stat) ? wval : {NSRC{1'b1}})) | src_req;
  assign mask_d = (bus_wr && hit_mask) ? wval : mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_d;
      mask <= mask_d;
      irq  <= |(stat_d & mask_d);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_stat)      bus_rdata[NSRC-1:0] = stat;
    else if (hit_mask) bus_rdata[NSRC-1:0] = mask;
  end
endmodule

// File: rtl/irq_stat_mask_chk.sv
module irq_stat_mask_chk #(
  parameter int          NSRC      = 11,
  parameter logic [31:0] MASK_ADDR = 32'h1F80_1074
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     bus_addr,
  input logic            bus_wr,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] stat,
  input logic [NSRC-1:0] mask,
  input logic            irq
);
  wire mask_wr = bus_wr && (bus_addr[28:2] == MASK_ADDR[28:2]);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (stat == '0 && mask == '0 && !irq)); // R1
  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ((stat & $past(src_req)) == $past(src_req))); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~($past(stat) | $past(src_req))) == '0)); // R3
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask)); // R5
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (irq == |(stat & mask))); // R6
endmodule

bind irq_stat_mask_ctrl irq_stat_mask_chk #(.NSRC(NSRC), .MASK_ADDR(MASK_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .src_req(src_req), .stat(stat), .mask(mask), .irq(irq)
);

// File: tb/tb_irq_stat_mask_ctrl.sv
module tb_irq_stat_mask_ctrl;
  localparam int NSRC = 11;
  localparam logic [31:0] S  = 32'h1F80_1070;
  localparam logic [31:0] M  = 32'h1F80_1074;
  localparam logic [31:0] OT = 32'h1F80_1078;

  typedef struct packed {
    logic        wr;
    logic [31:0] waddr;
    logic [31:0] wdata;
    logic [10:0] src;
    logic [31:0] raddr;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, S, 32'h0, 11'h008, S, 32'h008, 1'b0, 4'd2},           // R2 DMA bit 3, masked
    '{1'b1, M, 32'h008, 11'h000, S, 32'h008, 1'b1, 4'd6},         // R6 mask exposes pending
    '{1'b1, M, 32'hFFFF_FFFF, 11'h000, M, 32'h7FF, 1'b1, 4'd9},   // R5 R9 upper bits zero
    '{1'b1, S, 32'hFFFF_FFF7, 11'h000, S, 32'h000, 1'b0, 4'd3},   // R3 ack bit 3
    '{1'b0, S, 32'h0, 11'h403, S, 32'h403, 1'b1, 4'd2},           // R2 two sources
    '{1'b1, S, 32'hFFFF_FFFD, 11'h002, S, 32'h403, 1'b1, 4'd4},   // R4 set beats ack
    '{1'b1, 32'h9F80_1070, 32'hFFFF_FFFE, 11'h000, S, 32'h402, 1'b1, 4'd7}, // R7 mirror status
    '{1'b1, 32'hBF80_1074, 32'h0, 11'h000, M, 32'h000, 1'b0, 4'd7},          // R7 mirror mask
    '{1'b1, OT, 32'h0, 11'h000, S, 32'h402, 1'b0, 4'd8},          // R8 foreign write
    '{1'b0, S, 32'h0, 11'h000, OT, 32'h000, 1'b0, 4'd8},          // R8 foreign read
    '{1'b1, S, 32'h0000_FFFD, 11'h000, S, 32'h400, 1'b0, 4'd3},   // R3 16-bit ack
    '{1'b1, M, 32'h0000_0400, 11'h000, M, 32'h400, 1'b1, 4'd6},   // R6 irq rises
    '{1'b1, S, 32'h0000_0000, 11'h000, S, 32'h000, 1'b0, 4'd6}    // R6 irq falls on ack
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [31:0] bus_addr = S, bus_wdata = 0, bus_rdata;
  logic [NSRC-1:0] src_req = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_stat_mask_ctrl #(.NSRC(NSRC)) dut (.*);

  task automatic chk(input logic [31:0] rd, input logic ir, input int r);
    checks++;
    if (bus_rdata !== rd || irq !== ir) begin
      fails++;
      $display("FAIL R%0d: rdata=%h irq=%b expected rdata=%h irq=%b", r, bus_rdata, irq, rd, ir);
    end
  endtask

  task automatic rd_at(input logic [31:0] a);
    @(negedge clk);
    bus_wr = 0; src_req = 0; bus_addr = a;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_at(S); chk(32'h0, 1'b0, 1); // R1 status
    rd_at(M); chk(32'h0, 1'b0, 1); // R1 mask
    foreach (VEC[i]) begin
      @(negedge clk);
      bus_wr = VEC[i].wr; bus_addr = VEC[i].waddr;
      bus_wdata = VEC[i].wdata; src_req = VEC[i].src;
      rd_at(VEC[i].raddr);
      chk(VEC[i].exp_rd, VEC[i].exp_irq, int'(VEC[i].req));
    end
    // R1 reset clears live state
    @(negedge clk);
    bus_wr = 1; bus_addr = M; bus_wdata = 32'h7FF; src_req = 11'h7FF;
    @(negedge clk);
    bus_wr = 0; src_req = 0; rst_n = 0;
    @(negedge clk);
    rst_n = 1; bus_addr = S; #1; chk(32'h0, 1'b0, 1); // R1
    rd_at(M); chk(32'h0, 1'b0, 1);                     // R1
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run=hung expected=complete");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule